// File: doc/BRIEF.md
# Reset Configuration Word Loader

This block runs once at the end of every reset. It picks one of three boot sources (internal flash, the external multifunction port, or the internal special-function ROM) from two strap inputs and a persistent device-lock flag. It then reads four bytes of a 32-bit system configuration word from that source. It assembles the word into a control register and, one cycle later, releases the processor by raising a run output.

The lock flag is set by every power-on reset and is changed only through a register-write port. While it is set, the external multifunction port is disabled and can never be chosen as a boot source. External boot can therefore only follow a warm reset that comes after software has cleared the lock. Each source behaves as a byte-wide memory. When the block raises that source's read strobe with an address, the source presents the addressed byte during the following cycle.

Top module: `cfg_word_loader`

## Requirements
- R1: A power-on reset sets the lock flag, drives `ext_port_en` low, clears `cfg_word` to zero and holds `cpu_run` low.
- R2: After reset release the block reads exactly four bytes from the selected source, at byte addresses 0x20, 0x21, 0x22, 0x23 in that order. It places address 0x20 in bits 7:0 and address 0x23 in bits 31:24 of `cfg_word`.
- R3: With `strap_rom` = 1 the word comes from the special-function ROM, whatever `strap_mode` and the lock flag hold.
- R4: With `strap_rom` = 0 and `strap_mode` = 0 the word comes from internal flash, whatever the lock flag holds.
- R5: With `strap_rom` = 0 and `strap_mode` = 1 the word comes from internal flash when the lock flag is 1, and from the external port when it is 0. The external strobe never rises while the lock flag is 1.
- R6: Outside reset, a cycle with `lock_wr_en` = 1 loads `lock_wr_data` into the lock flag. A write during either reset has no effect.
- R7: `ext_port_en` is 1 exactly when the lock flag is 0.
- R8: A warm reset keeps the lock flag. It clears `cfg_word` to zero and holds `cpu_run` low until the new fetch completes.
- R9: `cfg_word` is written once per reset. `cpu_run` rises on the clock edge after that write, and `cfg_word` stays unchanged while `cpu_run` is high.
- R10: The straps are sampled only on the first clock edge after reset is released. Later strap changes cause no further reads and leave `cfg_word` unchanged.
- R11: At most one read strobe is high in any cycle, and only the strobe of the selected source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_rst | input | 1 | Power-on reset, synchronous, active high |
| warm_rst | input | 1 | Warm reset, synchronous, active high |
| strap_mode | input | 1 | Strap choosing flash or external port when `strap_rom` is 0 |
| strap_rom | input | 1 | Strap forcing boot from the special-function ROM |
| rd_addr | output | ADDR_W (8) | Byte address for the active read strobe |
| flash_rd_en | output | 1 | Read strobe to internal flash |
| flash_rd_data | input | 8 | Flash byte, valid the cycle after the strobe |
| ext_rd_en | output | 1 | Read strobe to the external multifunction port |
| ext_rd_data | input | 8 | External byte, valid the cycle after the strobe |
| sfrom_rd_en | output | 1 | Read strobe to the special-function ROM |
| sfrom_rd_data | input | 8 | ROM byte, valid the cycle after the strobe |
| lock_wr_en | input | 1 | Software write strobe for the lock flag |
| lock_wr_data | input | 1 | Value written to the lock flag |
| ext_port_en | output | 1 | External multifunction port enable |
| cfg_word | output | 8*WORD_BYTES (32) | Control register holding the fetched word |
| cpu_run | output | 1 | Processor release |

## Verification
The bench targets the lock flag across reset types. It clears the lock, warm-boots from the external port, then power-cycles and writes the lock during a held reset. A design that keeps the lock through power-on, or accepts writes in reset, would boot externally or enable the port when it must not. Each source holds a word with four distinct bytes, so a reversed byte order, a wrong address or a read from the wrong source shows up as a word mismatch. The bench flips the straps right after the capture edge and again after boot, so a design that samples the straps continuously would re-read or change the word. It also checks that the control register changed exactly one cycle before `cpu_run` rose, which catches a run output that is early or late by one cycle.

// File: rtl/cwl_pkg.sv
package cwl_pkg;

    localparam int NUM_SRC = 3;

    // boot source encoding; the value is also the strobe index
    typedef enum logic [1:0] {
        SRC_FLASH = 2'd0,
        SRC_EXT   = 2'd1,
        SRC_SFROM = 2'd2
    } src_e;

    typedef enum logic [2:0] {
        ST_START,
        ST_REQ,
        ST_CAP,
        ST_DONE,
        ST_RUN
    } fetch_st_e;

    // boot source decision: ROM strap wins, external only when unlocked
    function automatic src_e pick_src(input logic mode, input logic rom, input logic locked);
        if (rom)
            return SRC_SFROM;
        else if (mode && !locked)
            return SRC_EXT;
        else
            return SRC_FLASH;
    endfunction

endpackage

// File: rtl/cwl_lock.sv
module cwl_lock (
    input  logic clk,
    input  logic por_rst,
    input  logic any_rst,
    input  logic wr_en,
    input  logic wr_data,
    output logic locked
);

    logic locked_q;

    always_ff @(posedge clk) begin
        if (por_rst)
            locked_q <= 1'b1;
        else if (wr_en && !any_rst)
            locked_q <= wr_data;
    end

    assign locked = locked_q;

    // R6 / R8: without an accepted write the flag holds, warm reset included
    p_lock_hold_r6: assert property (@(posedge clk) disable iff (por_rst)
        !(wr_en && !any_rst) |=> $stable(locked_q));

endmodule

// File: rtl/cwl_strap_cap.sv
module cwl_strap_cap
    import cwl_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic cap_en,
    input  logic mode,
    input  logic rom,
    input  logic locked,
    output src_e src
);

    src_e src_q;

    always_ff @(posedge clk) begin
        if (rst)
            src_q <= SRC_FLASH;
        else if (cap_en)
            src_q <= pick_src(mode, rom, locked);
    end

    assign src = src_q;

    // R10: selection only moves on the capture cycle
    p_src_frozen_r10: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> $stable(src_q));

endmodule

// File: rtl/cwl_fetch.sv
module cwl_fetch
    import cwl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int WORD_BYTES = 4,
    parameter int CW_BASE    = 'h20
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [7:0]              byte_in,
    output logic                    cap_en,
    output logic                    rd_req,
    output logic [ADDR_W-1:0]       rd_addr,
    output logic [8*WORD_BYTES-1:0] cfg,
    output logic                    run
);

    localparam int IDX_W  = (WORD_BYTES > 1) ? $clog2(WORD_BYTES) : 1;
    localparam int WORD_W = 8 * WORD_BYTES;

    fetch_st_e         state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [WORD_W-1:0] asm_q;
    logic [WORD_W-1:0] asm_next;
    logic [WORD_W-1:0] cfg_q;
    logic              run_q;

    // little-endian placement of the returning byte
    always_comb begin
        asm_next = asm_q;
        asm_next[8*int'(idx_q) +: 8] = byte_in;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_START;
            idx_q   <= '0;
            asm_q   <= '0;
            cfg_q   <= '0;
            run_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_START: begin
                    idx_q   <= '0;
                    state_q <= ST_REQ;
                end
                ST_REQ: state_q <= ST_CAP;
                ST_CAP: begin
                    asm_q <= asm_next;
                    if (idx_q == IDX_W'(WORD_BYTES - 1)) begin
                        cfg_q   <= asm_next;
                        state_q <= ST_DONE;
                    end else begin
                        idx_q   <= idx_q + 1'b1;
                        state_q <= ST_REQ;
                    end
                end
                ST_DONE: begin
                    run_q   <= 1'b1;
                    state_q <= ST_RUN;
                end
                default: ;
            endcase
        end
    end

    assign cap_en  = (state_q == ST_START);
    assign rd_req  = (state_q == ST_REQ);
    assign rd_addr = ADDR_W'(CW_BASE) + ADDR_W'(idx_q);
    assign cfg     = cfg_q;
    assign run     = run_q;

    // R8: first cycle after any reset starts clean
    p_clean_after_reset_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (cfg_q == '0 && !run_q));

    // R9: control register frozen once the processor runs
    p_cfg_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        run_q |=> $stable(cfg_q));

endmodule

// File: rtl/cfg_word_loader.sv
module cfg_word_loader
    import cwl_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int WORD_BYTES = 4,
    parameter int CW_BASE    = 'h20
) (
    input  logic                    clk,
    input  logic                    por_rst,
    input  logic                    warm_rst,
    input  logic                    strap_mode,
    input  logic                    strap_rom,
    output logic [ADDR_W-1:0]       rd_addr,
    output logic                    flash_rd_en,
    input  logic [7:0]              flash_rd_data,
    output logic                    ext_rd_en,
    input  logic [7:0]              ext_rd_data,
    output logic                    sfrom_rd_en,
    input  logic [7:0]              sfrom_rd_data,
    input  logic                    lock_wr_en,
    input  logic                    lock_wr_data,
    output logic                    ext_port_en,
    output logic [8*WORD_BYTES-1:0] cfg_word,
    output logic                    cpu_run
);

    logic               rst;
    logic               locked;
    logic               cap_en;
    logic               rd_req;
    logic [7:0]         byte_in;
    src_e               src;
    logic [NUM_SRC-1:0] rd_en_vec;

    assign rst = por_rst | warm_rst;

    cwl_lock u_lock (
        .clk     (clk),
        .por_rst (por_rst),
        .any_rst (rst),
        .wr_en   (lock_wr_en),
        .wr_data (lock_wr_data),
        .locked  (locked)
    );

    cwl_strap_cap u_strap (
        .clk    (clk),
        .rst    (rst),
        .cap_en (cap_en),
        .mode   (strap_mode),
        .rom    (strap_rom),
        .locked (locked),
        .src    (src)
    );

    cwl_fetch #(
        .ADDR_W     (ADDR_W),
        .WORD_BYTES (WORD_BYTES),
        .CW_BASE    (CW_BASE)
    ) u_fetch (
        .clk     (clk),
        .rst     (rst),
        .byte_in (byte_in),
        .cap_en  (cap_en),
        .rd_req  (rd_req),
        .rd_addr (rd_addr),
        .cfg     (cfg_word),
        .run     (cpu_run)
    );

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_strobe
        assign rd_en_vec[g] = rd_req && (int'(src) == g);
    end

    always_comb begin
        case (src)
            SRC_EXT:   byte_in = ext_rd_data;
            SRC_SFROM: byte_in = sfrom_rd_data;
            default:   byte_in = flash_rd_data;
        endcase
    end

    assign flash_rd_en = rd_en_vec[SRC_FLASH];
    assign ext_rd_en   = rd_en_vec[SRC_EXT];
    assign sfrom_rd_en = rd_en_vec[SRC_SFROM];
    assign ext_port_en = !locked;

    // R11: never two sources strobed together
    p_one_source_r11: assert property (@(posedge clk) disable iff (rst)
        $onehot0({flash_rd_en, ext_rd_en, sfrom_rd_en}));

    // R5: external reads only through an enabled port
    p_ext_unlocked_r5: assert property (@(posedge clk) disable iff (rst)
        ext_rd_en |-> ext_port_en);

endmodule

// File: tb/cfg_word_loader_tb_top.sv
module cfg_word_loader_tb_top;

    localparam int SF = 0;
    localparam int SE = 1;
    localparam int SR = 2;

    logic        clk = 1'b0;
    logic        por_rst = 1'b1;
    logic        warm_rst = 1'b0;
    logic        strap_mode = 1'b0;
    logic        strap_rom = 1'b0;
    logic [7:0]  rd_addr;
    logic        flash_rd_en, ext_rd_en, sfrom_rd_en;
    logic [7:0]  flash_rd_data = 8'h00;
    logic [7:0]  ext_rd_data = 8'h00;
    logic [7:0]  sfrom_rd_data = 8'h00;
    logic        lock_wr_en = 1'b0;
    logic        lock_wr_data = 1'b0;
    logic        ext_port_en;
    logic [31:0] cfg_word;
    logic        cpu_run;

    int total = 0;
    int bad = 0;
    bit lock_exp = 1'b1;

    logic [31:0] words [3];

    typedef struct {
        int          src;
        logic [31:0] word;
        string       tag;
    } exp_t;
    exp_t exp_q[$];

    always #10 clk = ~clk;

    cfg_word_loader dut_i (
        .clk           (clk),
        .por_rst       (por_rst),
        .warm_rst      (warm_rst),
        .strap_mode    (strap_mode),
        .strap_rom     (strap_rom),
        .rd_addr       (rd_addr),
        .flash_rd_en   (flash_rd_en),
        .flash_rd_data (flash_rd_data),
        .ext_rd_en     (ext_rd_en),
        .ext_rd_data   (ext_rd_data),
        .sfrom_rd_en   (sfrom_rd_en),
        .sfrom_rd_data (sfrom_rd_data),
        .lock_wr_en    (lock_wr_en),
        .lock_wr_data  (lock_wr_data),
        .ext_port_en   (ext_port_en),
        .cfg_word      (cfg_word),
        .cpu_run       (cpu_run)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pick_byte(input int s, input logic [7:0] a);
        int off;
        off = int'(a) - 'h20;
        if (off >= 0 && off < 4)
            return words[s][8*off +: 8];
        return 8'hEE;
    endfunction

    // source models: byte returned the cycle after the strobe
    initial begin
        words[SF] = 32'hA1B2_7F5F;
        words[SE] = 32'h0C0D_7F5E;
        words[SR] = 32'h5566_7788;
        forever begin
            @(posedge clk);
            if (flash_rd_en) flash_rd_data <= pick_byte(SF, rd_addr);
            if (ext_rd_en)   ext_rd_data   <= pick_byte(SE, rd_addr);
            if (sfrom_rd_en) sfrom_rd_data <= pick_byte(SR, rd_addr);
        end
    end

    // monitor: read order, strobe exclusivity, run timing, scoreboard pop
    initial begin
        int          cnt = 0;
        int          mask = 0;
        logic        prev_run = 1'b0;
        logic [31:0] prev_cfg = '0;
        logic [31:0] prev2_cfg = '0;
        forever begin
            @(negedge clk);
            if (por_rst || warm_rst) begin
                cnt = 0;
                mask = 0;
            end else begin
                int n;
                n = int'(flash_rd_en) + int'(ext_rd_en) + int'(sfrom_rd_en);
                if (n > 1)
                    chk(1'b0, "R11 several strobes", 32'(n), 32'd1);
                if (n == 1) begin
                    if (flash_rd_en) mask |= (1 << SF);
                    if (ext_rd_en)   mask |= (1 << SE);
                    if (sfrom_rd_en) mask |= (1 << SR);
                    chk(rd_addr == 8'(32'h20 + cnt), "R2 read address", 32'(rd_addr), 32'h20 + cnt);
                    chk(cnt < 4, "R10 extra read after fetch", 32'(cnt), 32'd3);
                    cnt++;
                end
                if (cpu_run && !prev_run) begin
                    chk(prev_cfg == cfg_word, "R9 word present before run", prev_cfg, cfg_word);
                    chk(prev2_cfg == '0, "R9 run one cycle after write", prev2_cfg, 32'h0);
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R9 unexpected run", 32'h1, 32'h0);
                    end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(cfg_word == e.word, {e.tag, " word (R2 byte order)"}, cfg_word, e.word);
                        chk(mask == (1 << e.src), {e.tag, " source strobed (R11)"}, 32'(mask), 32'(1 << e.src));
                        chk(cnt == 4, "R2 four reads", 32'(cnt), 32'd4);
                    end
                end
            end
            prev2_cfg = prev_cfg;
            prev_cfg  = cfg_word;
            prev_run  = cpu_run;
        end
    end

    task automatic write_lock(input bit v);
        @(posedge clk); #2;
        lock_wr_en = 1'b1;
        lock_wr_data = v;
        @(posedge clk); #2;
        lock_wr_en = 1'b0;
        lock_exp = v;
        @(negedge clk);
        chk(ext_port_en == !v, "R6 R7 port enable after lock write", 32'(ext_port_en), 32'(!v));
    endtask

    // driver: applies a reset, pushes the expected word, waits for run
    task automatic boot(input bit is_por, input bit m, input bit r, input int src,
                        input string tag, input bit flip, input bit wr_in_rst);
        exp_t e;
        logic [31:0] saved;
        @(posedge clk); #2;
        if (is_por) por_rst = 1'b1; else warm_rst = 1'b1;
        strap_mode = m;
        strap_rom = r;
        if (wr_in_rst) begin
            lock_wr_en = 1'b1;
            lock_wr_data = !lock_exp;
        end
        @(posedge clk); #2;
        lock_wr_en = 1'b0;
        if (is_por) lock_exp = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(cfg_word == '0, is_por ? "R1 cfg cleared" : "R8 cfg cleared", cfg_word, 32'h0);
        chk(!cpu_run, is_por ? "R1 run low" : "R8 run low", 32'(cpu_run), 32'h0);
        chk(ext_port_en == !lock_exp, is_por ? "R1 port disabled" : "R8 lock kept",
            32'(ext_port_en), 32'(!lock_exp));
        e.src = src;
        e.word = words[src];
        e.tag = tag;
        exp_q.push_back(e);
        @(posedge clk); #2;
        por_rst = 1'b0;
        warm_rst = 1'b0;
        if (flip) begin
            @(posedge clk); #2;
            strap_mode = !m;
            strap_rom = !r;
        end
        while (!cpu_run) @(negedge clk);
        repeat (2) @(negedge clk);
        if (wr_in_rst)
            chk(ext_port_en == !lock_exp, "R6 write in reset ignored", 32'(ext_port_en), 32'(!lock_exp));
        saved = cfg_word;
        @(posedge clk); #2;
        strap_mode = !strap_mode;
        strap_rom = !strap_rom;
        repeat (4) @(negedge clk);
        chk(cfg_word == saved && cpu_run, "R10 late strap change ignored", cfg_word, saved);
        chk(exp_q.size() == 0, {tag, " run seen"}, 32'(exp_q.size()), 32'h0);
        exp_q.delete();
    endtask

    initial begin
        #200_000_000;
        total++;
        bad++;
        $display("FAIL watchdog expired actual=hang expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        boot(1'b1, 1'b0, 1'b0, SF, "R4", 1'b0, 1'b0);
        boot(1'b1, 1'b1, 1'b1, SR, "R3", 1'b0, 1'b0);
        boot(1'b1, 1'b1, 1'b0, SF, "R5 locked", 1'b0, 1'b0);
        chk(ext_port_en == 1'b0, "R7 locked port off", 32'(ext_port_en), 32'h0);
        write_lock(1'b0);
        boot(1'b0, 1'b1, 1'b0, SE, "R5 unlocked", 1'b0, 1'b0);
        boot(1'b0, 1'b1, 1'b0, SE, "R10 flip after capture", 1'b1, 1'b0);
        boot(1'b0, 1'b1, 1'b1, SR, "R3 unlocked", 1'b0, 1'b0);
        boot(1'b0, 1'b0, 1'b0, SF, "R4 unlocked", 1'b0, 1'b0);
        boot(1'b1, 1'b1, 1'b0, SF, "R1 relock", 1'b0, 1'b0);
        boot(1'b0, 1'b1, 1'b0, SF, "R6 reset write", 1'b0, 1'b1);
        write_lock(1'b0);
        write_lock(1'b1);
        boot(1'b0, 1'b1, 1'b0, SF, "R5 relocked by write", 1'b0, 1'b0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule